// File: doc/BRIEF.md
# Keyboard controller register interface

This block is the register face of a simple keyboard controller as a host processor sees it. Two byte-wide I/O addresses are decoded. The status/command address (0x64) returns a status byte when read and takes a command byte when written. The data address (0x60) returns the buffered output byte when read and takes a data byte when written. On the device side, scancode bytes arrive as a one-cycle valid strobe with data, and three LED outputs show the lock-key state.

Each host write lands in a one-byte input buffer. The controller consumes that byte on the next clock. Consuming a command can do one of three things: start a self test that posts a pass byte, enable the keyboard path, or arm the controller so that the next data write is taken as the LED state. A one-byte output buffer holds either the latest accepted scancode or the self-test result. A status flag tells polling software when that buffer holds a byte. Reading the data address empties the buffer.

Top module: `kbc_regif`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the status byte reads 0x04, the data address reads 0x00 and all three LED outputs are 0. The keyboard path is disabled, so scancodes are dropped until the enable command 0xAE has been consumed.
- R2: A read of address 0x64 returns the status byte with no wait cycle. Bit 0 is output-buffer-full (OBF). Bit 1 is input-buffer-full (IBF). Bit 2 is the system flag, which is always 1. Bit 3 records which address the last host write went to (AL2). Bits 7 to 4 read 0. A read of any address other than 0x60 or 0x64 returns 0x00.
- R3: A host write to 0x60 or 0x64 sets IBF from the next cycle. IBF clears one cycle later unless another write follows. The same write sets AL2 to 1 for address 0x64 and to 0 for address 0x60, and AL2 holds that value until the next such write. Writes to other addresses change nothing.
- R4: Once the keyboard path is enabled, a scancode presented while OBF is 0 appears at address 0x60 on the next cycle, and OBF becomes 1 on that cycle.
- R5: A read of 0x60 with the read strobe returns the buffered byte and clears OBF on the next cycle. The byte stays readable after OBF clears.
- R6: A scancode that arrives while OBF is 1, or while the keyboard path is disabled, is dropped. The buffered byte and OBF keep their values.
- R7: When the controller consumes command 0xAA, the output buffer becomes 0x55 and OBF becomes 1. This replaces any byte that was already in the buffer.
- R8: When the controller consumes command 0xED, the next data-address write is taken as the LED state. Its bit 0 drives the scroll LED, bit 1 the num LED and bit 2 the caps LED. A data write with no 0xED pending leaves the LEDs unchanged.
- R9: A command byte other than 0xAA, 0xAE or 0xED changes only AL2 and IBF. OBF, the buffered byte, the LEDs and the enable state are left as they were.
- R10: If the output buffer is loaded on the same clock edge as it is read, the load wins and OBF stays 1 with the new byte. If the self-test result and a scancode are both due on the same edge, the self-test result wins and the scancode is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 8 | Host I/O address |
| busWrEn | input | 1 | Host write strobe |
| busWrData | input | 8 | Host write byte |
| busRdEn | input | 1 | Host read strobe; enables the read side effects |
| busRdData | output | 8 | Read byte for busAddr, combinational |
| scanValid | input | 1 | Scancode valid, one cycle per byte |
| scanData | input | 8 | Scancode byte |
| ledScroll | output | 1 | Scroll-lock LED |
| ledNum | output | 1 | Num-lock LED |
| ledCaps | output | 1 | Caps-lock LED |

## Verification
Scancodes are offered in three situations: with the keyboard path disabled, enabled with the buffer empty, and enabled with the buffer full. This shows that enable gating and full-buffer dropping are separate conditions. Data writes are issued both with and without a preceding 0xED, and an unknown command is placed between other commands, so that LED capture can be told apart from plain data and ignored commands. Reads, scancodes and the self-test result are made to collide on the same edge to pin down the load-over-clear and self-test-over-scancode priorities. A behavioural model compares the read byte and the LEDs on every cycle.

// File: rtl/kbc_pkg.sv
package kbc_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 8;
  localparam int LED_W  = 3;

  // status bit positions (software decodes these)
  localparam int ST_OBF = 0;
  localparam int ST_IBF = 1;
  localparam int ST_SYS = 2;
  localparam int ST_AL2 = 3;

  typedef struct packed {
    logic loadSelfTest;
    logic loadScan;
    logic clearObf;
    logic setLed;
  } kbcStrobes_t;

  typedef enum logic [2:0] {
    CK_NONE,
    CK_SELFTEST,
    CK_ENABLE,
    CK_ARMLED,
    CK_LEDDATA,
    CK_PLAINDATA,
    CK_UNKNOWN
  } cmdKind_t;
endpackage

// File: rtl/kbcCtrl.sv
module kbcCtrl
  import kbc_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int LW = LED_W,
  parameter logic [AW-1:0] CMD_ADDR  = 8'h64,
  parameter logic [AW-1:0] DATA_ADDR = 8'h60,
  parameter logic [DW-1:0] CMD_SELFTEST = 8'hAA,
  parameter logic [DW-1:0] CMD_ENABLE   = 8'hAE,
  parameter logic [DW-1:0] CMD_SETLED   = 8'hED
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] busAddr,
  input  logic          busWrEn,
  input  logic [DW-1:0] busWrData,
  input  logic          busRdEn,
  input  logic          scanValid,
  input  logic          obf,
  output kbcStrobes_t   strobes,
  output logic [LW-1:0] ledByte,
  output logic          ibf,
  output logic          al2
);
  logic          hitCmd, hitData, hostWr;
  logic [DW-1:0] inByte;
  logic          inIsCmd;
  logic          kbdEnable;
  logic          ledPending;
  cmdKind_t      kind;

  assign hitCmd  = (busAddr == CMD_ADDR);
  assign hitData = (busAddr == DATA_ADDR);
  assign hostWr  = busWrEn && (hitCmd || hitData);

  always_comb begin
    kind = CK_NONE;
    if (ibf) begin
      if (inIsCmd) begin
        if (inByte == CMD_SELFTEST)    kind = CK_SELFTEST;
        else if (inByte == CMD_ENABLE) kind = CK_ENABLE;
        else if (inByte == CMD_SETLED) kind = CK_ARMLED;
        else                           kind = CK_UNKNOWN;
      end else if (ledPending) begin
        kind = CK_LEDDATA;
      end else begin
        kind = CK_PLAINDATA;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ibf        <= 1'b0;
      al2        <= 1'b0;
      inByte     <= '0;
      inIsCmd    <= 1'b0;
      kbdEnable  <= 1'b0;
      ledPending <= 1'b0;
    end else begin
      ibf <= hostWr;
      if (hostWr) begin
        inByte  <= busWrData;
        inIsCmd <= hitCmd;
        al2     <= hitCmd;
      end
      if (kind == CK_ENABLE) kbdEnable <= 1'b1;
      if (kind == CK_ARMLED)       ledPending <= 1'b1;
      else if (kind == CK_LEDDATA) ledPending <= 1'b0;
    end
  end

  always_comb begin
    strobes.loadSelfTest = (kind == CK_SELFTEST);
    strobes.setLed       = (kind == CK_LEDDATA);
    strobes.loadScan     = scanValid && kbdEnable && !obf;
    strobes.clearObf     = busRdEn && hitData;
  end

  assign ledByte = inByte[LW-1:0];

  // R3: a decoded host write raises the input-buffer flag next cycle
  a_r3_ibf_set: assert property (@(posedge clk) disable iff (!rstN)
    hostWr |=> ibf);
  // R3: the flag drops after one cycle without a new write
  a_r3_ibf_clear: assert property (@(posedge clk) disable iff (!rstN)
    (ibf && !hostWr) |=> !ibf);
  // R3: AL2 follows the address of the last decoded write
  a_r3_al2_cmd: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && hitCmd) |=> al2);
  // R6: no scancode is taken while the buffer is full
  a_r6_no_load_full: assert property (@(posedge clk) disable iff (!rstN)
    obf |-> !strobes.loadScan);
  // R1: disabled path never loads a scancode
  a_r1_disabled: assert property (@(posedge clk) disable iff (!rstN)
    !kbdEnable |-> !strobes.loadScan);
endmodule

// File: rtl/kbcDatapath.sv
module kbcDatapath
  import kbc_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int LW = LED_W,
  parameter logic [AW-1:0] CMD_ADDR  = 8'h64,
  parameter logic [AW-1:0] DATA_ADDR = 8'h60,
  parameter logic [DW-1:0] SELFTEST_PASS = 8'h55
) (
  input  logic          clk,
  input  logic          rstN,
  input  kbcStrobes_t   strobes,
  input  logic [LW-1:0] ledByte,
  input  logic [DW-1:0] scanData,
  input  logic          ibf,
  input  logic          al2,
  input  logic [AW-1:0] busAddr,
  output logic          obf,
  output logic [DW-1:0] busRdData,
  output logic [LW-1:0] leds
);
  logic [DW-1:0] outBuf;
  logic [DW-1:0] status;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outBuf <= '0;
      obf    <= 1'b0;
    end else if (strobes.loadSelfTest) begin
      outBuf <= SELFTEST_PASS;
      obf    <= 1'b1;
    end else if (strobes.loadScan) begin
      outBuf <= scanData;
      obf    <= 1'b1;
    end else if (strobes.clearObf) begin
      obf    <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               leds <= '0;
    else if (strobes.setLed) leds <= ledByte;
  end

  always_comb begin
    status         = '0;
    status[ST_OBF] = obf;
    status[ST_IBF] = ibf;
    status[ST_SYS] = 1'b1;
    status[ST_AL2] = al2;
  end

  always_comb begin
    if (busAddr == CMD_ADDR)       busRdData = status;
    else if (busAddr == DATA_ADDR) busRdData = outBuf;
    else                           busRdData = '0;
  end

  // R6: a full buffer holds its byte unless a self test replaces it
  a_r6_hold_full: assert property (@(posedge clk) disable iff (!rstN)
    (obf && !strobes.loadSelfTest) |=> $stable(outBuf));
  // R5: a read with nothing loading empties the buffer
  a_r5_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.clearObf && !strobes.loadSelfTest && !strobes.loadScan) |=> !obf);
  // R7: self test posts the pass byte
  a_r7_selftest: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadSelfTest |=> (obf && outBuf == SELFTEST_PASS));
  // R10: a load beats a same-edge read
  a_r10_load_wins: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.loadScan && strobes.clearObf) |=> obf);
  // R8: LEDs move only on an LED data byte
  a_r8_led_stable: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.setLed |=> $stable(leds));
endmodule

// File: rtl/kbc_regif.sv
module kbc_regif
  import kbc_pkg::*;
#(
  parameter logic [ADDR_W-1:0] CMD_ADDR  = 8'h64,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 8'h60,
  parameter logic [DATA_W-1:0] CMD_SELFTEST  = 8'hAA,
  parameter logic [DATA_W-1:0] CMD_ENABLE    = 8'hAE,
  parameter logic [DATA_W-1:0] CMD_SETLED    = 8'hED,
  parameter logic [DATA_W-1:0] SELFTEST_PASS = 8'h55
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busRdEn,
  output logic [DATA_W-1:0] busRdData,
  input  logic              scanValid,
  input  logic [DATA_W-1:0] scanData,
  output logic              ledScroll,
  output logic              ledNum,
  output logic              ledCaps
);
  kbcStrobes_t      strobes;
  logic [LED_W-1:0] ledByte;
  logic [LED_W-1:0] leds;
  logic             ibf, al2, obf;

  kbcCtrl #(
    .CMD_ADDR(CMD_ADDR), .DATA_ADDR(DATA_ADDR),
    .CMD_SELFTEST(CMD_SELFTEST), .CMD_ENABLE(CMD_ENABLE), .CMD_SETLED(CMD_SETLED)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdEn(busRdEn), .scanValid(scanValid),
    .obf(obf), .strobes(strobes), .ledByte(ledByte), .ibf(ibf), .al2(al2)
  );

  kbcDatapath #(
    .CMD_ADDR(CMD_ADDR), .DATA_ADDR(DATA_ADDR), .SELFTEST_PASS(SELFTEST_PASS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .ledByte(ledByte),
    .scanData(scanData), .ibf(ibf), .al2(al2), .busAddr(busAddr),
    .obf(obf), .busRdData(busRdData), .leds(leds)
  );

  assign ledScroll = leds[0];
  assign ledNum    = leds[1];
  assign ledCaps   = leds[2];
endmodule

// File: tb/kbc_regif_tb.sv
module kbc_regif_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] busAddr = 8'h00;
  logic       busWrEn = 1'b0;
  logic [7:0] busWrData = 8'h00;
  logic       busRdEn = 1'b0;
  logic [7:0] busRdData;
  logic       scanValid = 1'b0;
  logic [7:0] scanData = 8'h00;
  logic       ledScroll, ledNum, ledCaps;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int cycles = 0;

  // behavioural reference state
  int mObf = 0, mOut = 0, mIbf = 0, mAl2 = 0, mEn = 0, mPend = 0, mLed = 0;
  int mInByte = 0, mInCmd = 0;

  kbc_regif u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdEn(busRdEn), .busRdData(busRdData),
    .scanValid(scanValid), .scanData(scanData),
    .ledScroll(ledScroll), .ledNum(ledNum), .ledCaps(ledCaps)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mObf = 0; mOut = 0; mIbf = 0; mAl2 = 0; mEn = 0; mPend = 0; mLed = 0;
      mInByte = 0; mInCmd = 0;
    end else begin
      int nObf, nOut, nEn;
      nObf = mObf; nOut = mOut; nEn = mEn;
      if (busRdEn && busAddr == 8'h60) nObf = 0;
      if (mEn != 0 && scanValid && mObf == 0) begin nOut = scanData; nObf = 1; end
      if (mIbf != 0) begin
        if (mInCmd != 0) begin
          if (mInByte == 8'hAA) begin nOut = 8'h55; nObf = 1; end
          else if (mInByte == 8'hAE) nEn = 1;
          else if (mInByte == 8'hED) mPend = 1;
        end else if (mPend != 0) begin
          mLed = mInByte & 7; mPend = 0;
        end
      end
      mObf = nObf; mOut = nOut; mEn = nEn;
      mIbf = 0;
      if (busWrEn && (busAddr == 8'h60 || busAddr == 8'h64)) begin
        mIbf = 1; mInByte = busWrData; mInCmd = (busAddr == 8'h64) ? 1 : 0;
        mAl2 = mInCmd;
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!done) begin
      cycles++;
      if (busAddr == 8'h64)
        check("R2 status vs model", busRdData, (mAl2 << 3) | 4 | (mIbf << 1) | mObf);
      else if (busAddr == 8'h60)
        check("R4 data vs model", busRdData, mOut);
      else
        check("R2 other address", busRdData, 0);
      check("R8 leds vs model", {ledCaps, ledNum, ledScroll}, mLed);
      if (cycles > WATCHDOG) begin
        fails++; checks++;
        $display("FAIL watchdog: got %0d cycles expected below %0d", cycles, WATCHDOG);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    busWrEn = 1'b0; busRdEn = 1'b0; scanValid = 1'b0;
  endtask

  task automatic hostWrite(input logic [7:0] a, input logic [7:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1; cyc(); idle();
  endtask

  task automatic scan(input logic [7:0] d);
    scanData = d; scanValid = 1'b1; cyc(); idle();
  endtask

  // look at an address for one idle cycle; returns the byte seen
  task automatic peek(input logic [7:0] a, output int v);
    busAddr = a;
    @(negedge clk); v = busRdData;
    cyc();
  endtask

  initial begin
    int v;
    repeat (3) @(posedge clk);
    #1;
    busAddr = 8'h64;
    @(negedge clk);
    check("R1 status in reset", busRdData, 8'h04);
    rstN = 1'b1;
    cyc();
    peek(8'h64, v); check("R1 status after reset", v, 8'h04);
    peek(8'h60, v); check("R1 data after reset", v, 8'h00);
    check("R1 leds after reset", {ledCaps, ledNum, ledScroll}, 0);
    peek(8'h20, v); check("R2 unmapped address", v, 8'h00);

    scan(8'h1C);
    peek(8'h64, v); check("R1 scancode dropped while disabled", v, 8'h04);

    hostWrite(8'h64, 8'hAE);
    peek(8'h64, v); check("R3 IBF and AL2 after command write", v, 8'h0E);
    peek(8'h64, v); check("R3 IBF cleared, AL2 held", v, 8'h0C);

    scan(8'h1C);
    peek(8'h64, v); check("R4 OBF after scancode", v, 8'h0D);
    peek(8'h60, v); check("R4 scancode in buffer", v, 8'h1C);

    scan(8'h32);
    peek(8'h60, v); check("R6 full buffer keeps old byte", v, 8'h1C);
    peek(8'h64, v); check("R6 OBF still set", v, 8'h0D);

    busAddr = 8'h60; busRdEn = 1'b1;
    @(negedge clk); check("R5 read returns byte", busRdData, 8'h1C);
    cyc(); idle();
    peek(8'h64, v); check("R5 OBF cleared by read", v, 8'h0C);
    peek(8'h60, v); check("R5 byte retained after read", v, 8'h1C);

    hostWrite(8'h60, 8'h07);
    peek(8'h64, v); check("R3 AL2 low after data write", v, 8'h06);
    peek(8'h64, v);
    check("R8 plain data leaves leds", {ledCaps, ledNum, ledScroll}, 0);

    hostWrite(8'h64, 8'hED);
    hostWrite(8'h60, 8'h05);
    peek(8'h64, v);
    peek(8'h64, v);
    check("R8 led byte applied", {ledCaps, ledNum, ledScroll}, 3'b101);
    hostWrite(8'h60, 8'h02);
    peek(8'h64, v); peek(8'h64, v);
    check("R8 second data write ignored for leds", {ledCaps, ledNum, ledScroll}, 3'b101);

    hostWrite(8'h64, 8'h12);
    peek(8'h64, v); check("R9 unknown command sets only IBF/AL2", v, 8'h0E);
    peek(8'h64, v); check("R9 unknown command status after", v, 8'h0C);
    check("R9 unknown command leds", {ledCaps, ledNum, ledScroll}, 3'b101);
    scan(8'h2A);
    peek(8'h60, v); check("R9 enable kept after unknown command", v, 8'h2A);

    hostWrite(8'h64, 8'hAA);
    peek(8'h64, v);
    peek(8'h60, v); check("R7 self test replaces byte", v, 8'h55);
    peek(8'h64, v); check("R7 OBF after self test", v, 8'h0D);

    busAddr = 8'h60; busRdEn = 1'b1; cyc(); idle();
    peek(8'h64, v); check("R5 cleared before collision test", v, 8'h0C);
    busAddr = 8'h60; busRdEn = 1'b1; scanData = 8'h3B; scanValid = 1'b1; cyc(); idle();
    peek(8'h64, v); check("R10 load wins over read", v, 8'h0D);
    peek(8'h60, v); check("R10 new byte after collision", v, 8'h3B);

    busAddr = 8'h60; busRdEn = 1'b1; cyc(); idle();
    hostWrite(8'h64, 8'hAA);
    busAddr = 8'h60; busRdEn = 1'b1; scanData = 8'h44; scanValid = 1'b1; cyc(); idle();
    peek(8'h60, v); check("R10 self test beats scancode", v, 8'h55);
    peek(8'h64, v); check("R10 OBF after self test collision", v, 8'h0D);

    repeat (3) cyc();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule